// File: doc/BRIEF.md
# Banked Flash Program/Erase Scheduler

This block arbitrates access to a banked flash array in which only one bank at a time may run a program or an erase. Each cycle it may take one request: a word address and a request kind (read, program, erase, suspend or resume). One cycle later it answers with accept or reject, an error marker, and the bank and block that the address decodes to. A modelled program/erase engine signals the end of the running operation with a completion pulse and an optional failure flag. The scheduler keeps the running bank, the held operations and a status word with busy, held, done and error flags.

The array map is asymmetric. Every bank holds a row of equal main blocks. In one bank, one main-block slot is split into a group of small parameter blocks. A configuration input places that parameter bank at the lowest or the highest bank, and the block numbering follows that choice. An erase may be held so that a program can run in another block. That program may itself be held so that reads can reach other blocks. Resumes unwind the two in that same nested order.

Top module: `mbsched`

## Requirements
- R1: With `topBoot` low, bank = the top BANK_BITS address bits, slot = address bits [MAIN_LOG2 +: SLOT_BITS], sub = bits [PARAM_LOG2 +: MAIN_LOG2-PARAM_LOG2]. Bank 0, slot 0 is the parameter group, with block = sub. Every other address gives block = bank*2^SLOT_BITS + slot + 2^(MAIN_LOG2-PARAM_LOG2) - 1.
- R2: With `topBoot` high, the highest bank's highest slot is the parameter group, with block = 2^(BANK_BITS+SLOT_BITS) - 1 + sub. Every other address gives block = bank*2^SLOT_BITS + slot.
- R3: `reqKind` codes are 0 none, 1 read, 2 program, 3 erase, 4 suspend, 5 resume; codes 6 and 7 act as none. For every code from 1 to 5, `respValid` is high in the next cycle, together with the accept and error result and the decoded bank and block of that request's address. For any other code, `respValid` is low in the next cycle.
- R4: A program or erase request is rejected while any operation is running, whatever its bank. An erase is also rejected while any operation is held. An accepted program or erase makes the status busy in the next cycle.
- R5: While an operation runs, a read to its bank is rejected and a read to any other bank is accepted.
- R6: A suspend while only an erase runs holds that erase. A program may then be accepted in any block except the held erase block. A later resume restarts the erase.
- R7: A suspend while a program runs holds the program. Reads to blocks other than the held ones are then accepted, including reads in the same bank. A suspend with nothing running is rejected and changes nothing.
- R8: Any read, program or erase that targets a held block is rejected with `respErr` high, and the status error flag is set.
- R9: A resume with nothing held is rejected and changes no status. With both an erase and a program held, the program resumes first. An erase cannot resume while a program is running.
- R10: Status bits are: bit0 busy, bit1 program held, bit2 erase held, bit3 done, bit4 error. A completion pulse ends the running operation and sets done. A completion pulse with `opFail` also sets error. An accepted program or erase clears done and error. A completion pulse with nothing running is ignored.
- R11: After reset, and after a reset applied during an operation, the status is zero, nothing is held and `respValid` is low.
- R12: `busyBank` shows the bank of the running operation, and is zero when nothing runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| topBoot | input | 1 | 1 places the parameter bank at the top of the address space |
| reqKind | input | 3 | Request code |
| reqAddr | input | ADDR_BITS | Word address of the request |
| opDone | input | 1 | Completion pulse from the program/erase engine |
| opFail | input | 1 | Failure qualifier for `opDone` |
| respValid | output | 1 | A response is present |
| respAccept | output | 1 | The request was accepted |
| respErr | output | 1 | The request hit a held block |
| respBank | output | BANK_BITS | Decoded bank of the request |
| respBlock | output | BLK_BITS | Decoded block index of the request |
| status | output | 5 | Status word |
| busyBank | output | BANK_BITS | Bank of the running operation |

## Verification
The bench builds the scheduler with four banks of eight slots, 16-word main blocks and 2-word parameter blocks. This gives a 9-bit address and 39 blocks. At this size the lowest and highest block numbers of both layouts, every bank boundary and the whole parameter group can be reached with short literal addresses. The same small map lets a single sequence walk through erase hold, nested program, program hold and the ordered resumes, and check the status word at every step.

// File: rtl/mbsched_pkg.sv
package mbsched_pkg;

  typedef enum logic [2:0] {
    REQ_NONE    = 3'd0,
    REQ_READ    = 3'd1,
    REQ_PROG    = 3'd2,
    REQ_ERASE   = 3'd3,
    REQ_SUSPEND = 3'd4,
    REQ_RESUME  = 3'd5
  } reqKind_e;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RUN  = 2'd1,
    OP_HELD = 2'd2
  } opState_e;

  // strobes and levels from control to datapath
  typedef struct packed {
    logic loadProg;
    logic loadErase;
    logic respValid;
    logic respAccept;
    logic respErr;
    logic progRun;
    logic eraseRun;
  } ctlStrobe_t;

  // bit0 busy ... bit4 error
  typedef struct packed {
    logic error;
    logic done;
    logic eraseHeld;
    logic progHeld;
    logic busy;
  } status_t;

endpackage

// File: rtl/mbsched_decode.sv
module mbsched_decode #(
  parameter int BANK_BITS  = 5,
  parameter int SLOT_BITS  = 3,
  parameter int MAIN_LOG2  = 15,
  parameter int PARAM_LOG2 = 12,
  parameter int BLK_BITS   = 9
) (
  input  logic                                         topBoot,
  input  logic [BANK_BITS+SLOT_BITS+MAIN_LOG2-1:PARAM_LOG2] addrHi,
  output logic [BANK_BITS-1:0]                         bankIdx,
  output logic [BLK_BITS-1:0]                          blockIdx
);

  localparam int ADDR_BITS   = BANK_BITS + SLOT_BITS + MAIN_LOG2;
  localparam int SUB_BITS    = MAIN_LOG2 - PARAM_LOG2;
  localparam int MAIN_SLOTS  = 2 ** (BANK_BITS + SLOT_BITS);
  localparam int PARAM_COUNT = 2 ** SUB_BITS;
  localparam int TOP_BASE    = MAIN_SLOTS - 1;
  localparam int BOT_SHIFT   = PARAM_COUNT - 1;

  logic [SLOT_BITS-1:0] slotIdx;
  logic [SUB_BITS-1:0]  subIdx;
  logic                 inParam;
  logic [BLK_BITS-1:0]  linearIdx;

  always_comb begin
    bankIdx   = addrHi[ADDR_BITS-1 -: BANK_BITS];
    slotIdx   = addrHi[MAIN_LOG2 +: SLOT_BITS];
    subIdx    = addrHi[PARAM_LOG2 +: SUB_BITS];
    linearIdx = BLK_BITS'({bankIdx, slotIdx});
    if (topBoot) begin
      inParam  = (bankIdx == {BANK_BITS{1'b1}}) && (slotIdx == {SLOT_BITS{1'b1}});
      blockIdx = inParam ? BLK_BITS'(TOP_BASE) + BLK_BITS'(subIdx) : linearIdx;
    end else begin
      inParam  = (bankIdx == '0) && (slotIdx == '0);
      blockIdx = inParam ? BLK_BITS'(subIdx) : linearIdx + BLK_BITS'(BOT_SHIFT);
    end
  end

endmodule

// File: rtl/mbsched_datapath.sv
module mbsched_datapath
  import mbsched_pkg::*;
#(
  parameter int BANK_BITS  = 5,
  parameter int SLOT_BITS  = 3,
  parameter int MAIN_LOG2  = 15,
  parameter int PARAM_LOG2 = 12,
  parameter int BLK_BITS   = 9,
  parameter int ADDR_BITS  = 23
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 topBoot,
  input  logic [ADDR_BITS-1:0] reqAddr,
  input  ctlStrobe_t           ctl,
  output logic                 hitProgBank,
  output logic                 hitEraseBank,
  output logic                 hitProgBlk,
  output logic                 hitEraseBlk,
  output logic                 respValid,
  output logic                 respAccept,
  output logic                 respErr,
  output logic [BANK_BITS-1:0] respBank,
  output logic [BLK_BITS-1:0]  respBlock,
  output logic [BANK_BITS-1:0] busyBank
);

  logic [BANK_BITS-1:0] curBank;
  logic [BLK_BITS-1:0]  curBlock;
  logic [BANK_BITS-1:0] progBank, eraseBank;
  logic [BLK_BITS-1:0]  progBlk, eraseBlk;
  logic                 unusedWordBits;

  assign unusedWordBits = ^reqAddr[PARAM_LOG2-1:0];

  mbsched_decode #(
    .BANK_BITS (BANK_BITS),
    .SLOT_BITS (SLOT_BITS),
    .MAIN_LOG2 (MAIN_LOG2),
    .PARAM_LOG2(PARAM_LOG2),
    .BLK_BITS  (BLK_BITS)
  ) u_decode (
    .topBoot (topBoot),
    .addrHi  (reqAddr[ADDR_BITS-1:PARAM_LOG2]),
    .bankIdx (curBank),
    .blockIdx(curBlock)
  );

  assign hitProgBank  = (curBank == progBank);
  assign hitEraseBank = (curBank == eraseBank);
  assign hitProgBlk   = (curBlock == progBlk);
  assign hitEraseBlk  = (curBlock == eraseBlk);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progBank  <= '0;
      progBlk   <= '0;
      eraseBank <= '0;
      eraseBlk  <= '0;
    end else begin
      if (ctl.loadProg) begin
        progBank <= curBank;
        progBlk  <= curBlock;
      end
      if (ctl.loadErase) begin
        eraseBank <= curBank;
        eraseBlk  <= curBlock;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid  <= 1'b0;
      respAccept <= 1'b0;
      respErr    <= 1'b0;
      respBank   <= '0;
      respBlock  <= '0;
    end else begin
      respValid  <= ctl.respValid;
      respAccept <= ctl.respAccept;
      respErr    <= ctl.respErr;
      if (ctl.respValid) begin
        respBank  <= curBank;
        respBlock <= curBlock;
      end
    end
  end

  always_comb begin
    if (ctl.progRun)       busyBank = progBank;
    else if (ctl.eraseRun) busyBank = eraseBank;
    else                   busyBank = '0;
  end

endmodule

// File: rtl/mbsched_ctrl.sv
module mbsched_ctrl
  import mbsched_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] reqKind,
  input  logic       opDone,
  input  logic       opFail,
  input  logic       hitProgBank,
  input  logic       hitEraseBank,
  input  logic       hitProgBlk,
  input  logic       hitEraseBlk,
  output ctlStrobe_t ctl,
  output status_t    stat
);

  opState_e progSt, eraseSt;
  opState_e progAft, eraseAft;
  opState_e progNx, eraseNx;
  logic     finish;
  logic     running, runBankHit, heldHit;
  logic     newOp;
  logic     doneQ, errQ;
  reqKind_e kind;

  assign kind = reqKind_e'(reqKind);

  // completion is applied before the request is judged
  always_comb begin
    progAft  = progSt;
    eraseAft = eraseSt;
    finish   = 1'b0;
    if (opDone) begin
      if (progSt == OP_RUN) begin
        progAft = OP_IDLE;
        finish  = 1'b1;
      end else if (eraseSt == OP_RUN) begin
        eraseAft = OP_IDLE;
        finish   = 1'b1;
      end
    end
  end

  always_comb begin
    running    = (progAft == OP_RUN) || (eraseAft == OP_RUN);
    runBankHit = ((progAft == OP_RUN) && hitProgBank) ||
                 ((eraseAft == OP_RUN) && hitEraseBank);
    heldHit    = ((progAft == OP_HELD) && hitProgBlk) ||
                 ((eraseAft == OP_HELD) && hitEraseBlk);
  end

  always_comb begin
    progNx         = progAft;
    eraseNx        = eraseAft;
    ctl            = '0;
    newOp          = 1'b0;
    case (kind)
      REQ_READ: begin
        ctl.respValid = 1'b1;
        if (heldHit)                    ctl.respErr    = 1'b1;
        else if (running && runBankHit) ctl.respAccept = 1'b0;
        else                            ctl.respAccept = 1'b1;
      end
      REQ_PROG: begin
        ctl.respValid = 1'b1;
        if (heldHit) begin
          ctl.respErr = 1'b1;
        end else if (!running && (progAft == OP_IDLE)) begin
          ctl.respAccept = 1'b1;
          ctl.loadProg   = 1'b1;
          newOp          = 1'b1;
          progNx         = OP_RUN;
        end
      end
      REQ_ERASE: begin
        ctl.respValid = 1'b1;
        if (heldHit) begin
          ctl.respErr = 1'b1;
        end else if ((progAft == OP_IDLE) && (eraseAft == OP_IDLE)) begin
          ctl.respAccept = 1'b1;
          ctl.loadErase  = 1'b1;
          newOp          = 1'b1;
          eraseNx        = OP_RUN;
        end
      end
      REQ_SUSPEND: begin
        ctl.respValid = 1'b1;
        if (progAft == OP_RUN) begin
          progNx         = OP_HELD;
          ctl.respAccept = 1'b1;
        end else if (eraseAft == OP_RUN) begin
          eraseNx        = OP_HELD;
          ctl.respAccept = 1'b1;
        end
      end
      REQ_RESUME: begin
        ctl.respValid = 1'b1;
        if (progAft == OP_HELD) begin
          progNx         = OP_RUN;
          ctl.respAccept = 1'b1;
        end else if ((eraseAft == OP_HELD) && (progAft == OP_IDLE)) begin
          eraseNx        = OP_RUN;
          ctl.respAccept = 1'b1;
        end
      end
      default: ;
    endcase
    ctl.progRun  = (progSt == OP_RUN);
    ctl.eraseRun = (eraseSt == OP_RUN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progSt  <= OP_IDLE;
      eraseSt <= OP_IDLE;
      doneQ   <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      progSt  <= progNx;
      eraseSt <= eraseNx;
      if (newOp) begin
        doneQ <= 1'b0;
        errQ  <= 1'b0;
      end
      if (finish)           doneQ <= 1'b1;
      if (finish && opFail) errQ  <= 1'b1;
      if (ctl.respErr)      errQ  <= 1'b1;
    end
  end

  always_comb begin
    stat.busy      = (progSt == OP_RUN) || (eraseSt == OP_RUN);
    stat.progHeld  = (progSt == OP_HELD);
    stat.eraseHeld = (eraseSt == OP_HELD);
    stat.done      = doneQ;
    stat.error     = errQ;
  end

endmodule

// File: rtl/mbsched.sv
module mbsched
  import mbsched_pkg::*;
#(
  parameter int BANK_BITS  = 5,
  parameter int SLOT_BITS  = 3,
  parameter int MAIN_LOG2  = 15,
  parameter int PARAM_LOG2 = 12,
  localparam int ADDR_BITS = BANK_BITS + SLOT_BITS + MAIN_LOG2,
  localparam int BLK_BITS  = $clog2(2 ** (BANK_BITS + SLOT_BITS) - 1 + 2 ** (MAIN_LOG2 - PARAM_LOG2))
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 topBoot,
  input  logic [2:0]           reqKind,
  input  logic [ADDR_BITS-1:0] reqAddr,
  input  logic                 opDone,
  input  logic                 opFail,
  output logic                 respValid,
  output logic                 respAccept,
  output logic                 respErr,
  output logic [BANK_BITS-1:0] respBank,
  output logic [BLK_BITS-1:0]  respBlock,
  output logic [4:0]           status,
  output logic [BANK_BITS-1:0] busyBank
);

  ctlStrobe_t ctl;
  status_t    stat;
  logic       hitProgBank, hitEraseBank, hitProgBlk, hitEraseBlk;

  mbsched_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqKind     (reqKind),
    .opDone      (opDone),
    .opFail      (opFail),
    .hitProgBank (hitProgBank),
    .hitEraseBank(hitEraseBank),
    .hitProgBlk  (hitProgBlk),
    .hitEraseBlk (hitEraseBlk),
    .ctl         (ctl),
    .stat        (stat)
  );

  mbsched_datapath #(
    .BANK_BITS (BANK_BITS),
    .SLOT_BITS (SLOT_BITS),
    .MAIN_LOG2 (MAIN_LOG2),
    .PARAM_LOG2(PARAM_LOG2),
    .BLK_BITS  (BLK_BITS),
    .ADDR_BITS (ADDR_BITS)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .topBoot     (topBoot),
    .reqAddr     (reqAddr),
    .ctl         (ctl),
    .hitProgBank (hitProgBank),
    .hitEraseBank(hitEraseBank),
    .hitProgBlk  (hitProgBlk),
    .hitEraseBlk (hitEraseBlk),
    .respValid   (respValid),
    .respAccept  (respAccept),
    .respErr     (respErr),
    .respBank    (respBank),
    .respBlock   (respBlock),
    .busyBank    (busyBank)
  );

  assign status = stat;

endmodule

// File: rtl/mbsched_checker.sv
module mbsched_checker #(
  parameter int BANK_BITS = 5
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [2:0]           reqKind,
  input logic                 respValid,
  input logic                 respAccept,
  input logic                 respErr,
  input logic [4:0]           status,
  input logic [BANK_BITS-1:0] busyBank
);

  // R3: a coded request is answered in the next cycle
  p_resp_timing_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqKind >= 3'd1 && reqKind <= 3'd5) |=> respValid);

  p_no_resp_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(reqKind >= 3'd1 && reqKind <= 3'd5) |=> !respValid);

  // R8: an error reply is never an acceptance
  p_err_rejects_r8: assert property (@(posedge clk) disable iff (!rstN)
    respErr |-> (respValid && !respAccept));

  // R4: accepted program or erase leaves the scheduler busy
  p_accept_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respAccept && ($past(reqKind) == 3'd2 || $past(reqKind) == 3'd3))
      |-> status[0]);

  // R7: nothing runs while a program is held
  p_held_prog_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    status[1] |-> !status[0]);

  // R9: resume with nothing held changes nothing
  p_resume_none_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqKind == 3'd5 && status[2:0] == 3'b000) |=> (!respAccept && $stable(status)));

  // R9: program resumes before erase
  p_resume_order_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqKind == 3'd5 && status[1] && status[2]) |=> (status[0] && !status[1] && status[2]));

  // R12: idle scheduler reports bank zero
  p_busybank_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    !status[0] |-> (busyBank == '0));

endmodule

bind mbsched mbsched_checker #(.BANK_BITS(BANK_BITS)) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .reqKind   (reqKind),
  .respValid (respValid),
  .respAccept(respAccept),
  .respErr   (respErr),
  .status    (status),
  .busyBank  (busyBank)
);

// File: tb/mbsched_bench.sv
module mbsched_bench;

  localparam int BANK_BITS  = 2;
  localparam int SLOT_BITS  = 3;
  localparam int MAIN_LOG2  = 4;
  localparam int PARAM_LOG2 = 1;
  localparam int ADDR_BITS  = 9;
  localparam int BLK_BITS   = 6;
  localparam int NVEC       = 31;

  // {tag[33:30], top[29], kind[28:26], addr[25:17], done[16], fail[15],
  //  acc[14], err[13], bank[12:11], blk[10:5], stat[4:0]}
  localparam logic [33:0] TBL [0:NVEC-1] = '{
    {4'd5,  1'b0, 3'd1, 9'd160, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 6'd17, 5'h00}, // R5 read idle
    {4'd4,  1'b0, 3'd3, 9'd304, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 6'd26, 5'h01}, // R4 erase
    {4'd5,  1'b0, 3'd1, 9'd336, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 6'd28, 5'h01}, // R5 busy bank
    {4'd1,  1'b0, 3'd1, 9'd6,   1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 6'd3,  5'h01}, // R1 param blk
    {4'd4,  1'b0, 3'd2, 9'd128, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 6'd15, 5'h01}, // R4 other bank
    {4'd6,  1'b0, 3'd4, 9'd0,   1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 6'd0,  5'h04}, // R6 hold erase
    {4'd8,  1'b0, 3'd2, 9'd314, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 6'd26, 5'h14}, // R8 held blk
    {4'd6,  1'b0, 3'd2, 9'd320, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 6'd27, 5'h05}, // R6 nested prog
    {4'd5,  1'b0, 3'd1, 9'd400, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 6'd32, 5'h05}, // R5 other bank
    {4'd7,  1'b0, 3'd4, 9'd0,   1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 6'd0,  5'h06}, // R7 hold prog
    {4'd8,  1'b0, 3'd1, 9'd322, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 6'd27, 5'h16}, // R8 held prog
    {4'd8,  1'b0, 3'd1, 9'd304, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 6'd26, 5'h16}, // R8 held erase
    {4'd7,  1'b0, 3'd1, 9'd352, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 6'd29, 5'h16}, // R7 same bank
    {4'd4,  1'b0, 3'd3, 9'd128, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 6'd15, 5'h16}, // R4 erase held
    {4'd9,  1'b0, 3'd5, 9'd0,   1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 6'd0,  5'h15}, // R9 prog first
    {4'd9,  1'b0, 3'd5, 9'd0,   1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 6'd0,  5'h15}, // R9 erase blocked
    {4'd10, 1'b0, 3'd0, 9'd0,   1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 6'd0,  5'h1C}, // R10 done
    {4'd6,  1'b0, 3'd5, 9'd0,   1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 6'd0,  5'h19}, // R6 erase resume
    {4'd10, 1'b0, 3'd0, 9'd0,   1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 6'd0,  5'h18}, // R10 fail
    {4'd9,  1'b0, 3'd5, 9'd0,   1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 6'd0,  5'h18}, // R9 nothing held
    {4'd7,  1'b0, 3'd4, 9'd0,   1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 6'd0,  5'h18}, // R7 idle suspend
    {4'd10, 1'b0, 3'd2, 9'd16,  1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 6'd8,  5'h01}, // R10 clear flags
    {4'd10, 1'b0, 3'd0, 9'd0,   1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 6'd0,  5'h08}, // R10 done
    {4'd2,  1'b1, 3'd1, 9'd500, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 6'd33, 5'h08}, // R2 param
    {4'd2,  1'b1, 3'd1, 9'd480, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 6'd30, 5'h08}, // R2 main top bank
    {4'd2,  1'b1, 3'd1, 9'd510, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 6'd38, 5'h08}, // R2 max blk
    {4'd2,  1'b1, 3'd1, 9'd128, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 6'd8,  5'h08}, // R2 low bank
    {4'd2,  1'b1, 3'd3, 9'd510, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 6'd38, 5'h01}, // R2 erase param
    {4'd5,  1'b1, 3'd1, 9'd496, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 6'd31, 5'h01}, // R5 busy bank
    {4'd10, 1'b1, 3'd0, 9'd0,   1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 6'd0,  5'h08}, // R10 done
    {4'd1,  1'b0, 3'd1, 9'd496, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 6'd38, 5'h08}  // R1 max blk
  };

  logic                 clk = 1'b0;
  logic                 rstN;
  logic                 topBoot;
  logic [2:0]           reqKind;
  logic [ADDR_BITS-1:0] reqAddr;
  logic                 opDone, opFail;
  logic                 respValid, respAccept, respErr;
  logic [BANK_BITS-1:0] respBank, busyBank;
  logic [BLK_BITS-1:0]  respBlock;
  logic [4:0]           status;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  mbsched #(
    .BANK_BITS (BANK_BITS),
    .SLOT_BITS (SLOT_BITS),
    .MAIN_LOG2 (MAIN_LOG2),
    .PARAM_LOG2(PARAM_LOG2)
  ) u_mbsched (
    .clk(clk), .rstN(rstN), .topBoot(topBoot), .reqKind(reqKind),
    .reqAddr(reqAddr), .opDone(opDone), .opFail(opFail),
    .respValid(respValid), .respAccept(respAccept), .respErr(respErr),
    .respBank(respBank), .respBlock(respBlock), .status(status),
    .busyBank(busyBank)
  );

  task automatic check(input int tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL R%0d %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  // drive at a falling edge, let one rising edge pass, sample at the next falling edge
  task automatic step(input logic top, input logic [2:0] k, input logic [ADDR_BITS-1:0] a,
                      input logic d, input logic f);
    topBoot = top; reqKind = k; reqAddr = a; opDone = d; opFail = f;
    @(negedge clk);
    reqKind = 3'd0; opDone = 1'b0; opFail = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    rstN = 1'b0; topBoot = 1'b0; reqKind = 3'd0; reqAddr = '0;
    opDone = 1'b0; opFail = 1'b0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(11, "reset status", int'(status), 0);
    check(11, "reset respValid", int'(respValid), 0);
    check(12, "reset busyBank", int'(busyBank), 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      logic [33:0] v;
      int tg;
      v  = TBL[i];
      tg = int'(v[33:30]);
      step(v[29], v[28:26], v[25:17], v[16], v[15]);
      // R3: response presence follows the request code
      check(3, $sformatf("vec %0d respValid", i), int'(respValid), int'(v[28:26] != 3'd0));
      if (v[28:26] != 3'd0) begin
        check(tg, $sformatf("vec %0d accept", i), int'(respAccept), int'(v[14]));
        check(tg, $sformatf("vec %0d err", i), int'(respErr), int'(v[13]));
        check(tg, $sformatf("vec %0d bank", i), int'(respBank), int'(v[12:11]));
        check(tg, $sformatf("vec %0d block", i), int'(respBlock), int'(v[10:5]));
      end
      check(tg, $sformatf("vec %0d status", i), int'(status), int'(v[4:0]));
    end

    // R3: unused code 6 gives no response
    step(1'b0, 3'd6, 9'd0, 1'b0, 1'b0);
    check(3, "code 6 no response", int'(respValid), 0);

    // R12: running erase in bank 1 is reported
    step(1'b0, 3'd3, 9'd144, 1'b0, 1'b0);
    check(12, "busyBank erase", int'(busyBank), 1);
    // R11: reset in mid operation returns to idle
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(11, "reset mid op status", int'(status), 0);
    check(11, "reset mid op busyBank", int'(busyBank), 0);

    // R10: completion pulse while idle is ignored
    step(1'b0, 3'd0, 9'd0, 1'b1, 1'b1);
    check(10, "idle done ignored", int'(status), 0);

    // R12: program in bank 3, then hold it
    step(1'b0, 3'd2, 9'd448, 1'b0, 1'b0);
    check(12, "busyBank prog", int'(busyBank), 3);
    step(1'b0, 3'd4, 9'd0, 1'b0, 1'b0);
    check(12, "busyBank held", int'(busyBank), 0);
    check(7, "prog held status", int'(status), 5'h02);
    // R4: erase refused while a program is held
    step(1'b0, 3'd3, 9'd16, 1'b0, 1'b0);
    check(4, "erase while held", int'(respAccept), 0);
    step(1'b0, 3'd5, 9'd0, 1'b0, 1'b0);
    check(12, "busyBank resumed", int'(busyBank), 3);
    step(1'b0, 3'd0, 9'd0, 1'b1, 1'b0);
    check(10, "final done", int'(status), 5'h08);

    finishRun();
  end

endmodule